// File: doc/BRIEF.md
# Halted-Core Debug Register Port

This block gives an external bus agent a word-addressed window into a small processor core's 32-entry general-purpose register file and its 32-entry constants table. The agent issues single-cycle requests (valid, write flag, byte address, write data). Every request is accepted at once, and one response comes back on the next cycle. The block holds the register file itself. The core reaches that file through its own write port and a combinational read port, so a value written through the debug window is the value the core later sees.

Debug access is honoured only while the core is disabled. While the core runs, a debug write is dropped and a debug read returns zero, but the response still comes back on time. A write to general-purpose register 30 produces a one-cycle pulse output. This happens whether the debug port or the core performs the write, so a debug write has the same effect as an instruction write.

In the constants table, the lowest `CT_WR_CNT` entries are stored locally and can be written. The remaining entries are read-only and mirror a system input bus.

Top module: `dbg_regport`

## Requirements
- R1: After reset every general-purpose register and every writable constants entry reads zero, `rsp_valid` is low and `r30_pulse` is low.
- R2: General-purpose register y (0..31) sits at byte address 4*y. A debug write stores all 32 bits, and a later debug read returns them.
- R3: Constants entry y sits at byte address 0x80 + 4*y. For y below `CT_WR_CNT` (default 8), the entry stores a debug write, and a read returns it.
- R4: A constants entry y at or above `CT_WR_CNT` reads back slice (y - `CT_WR_CNT`) of `ct_ro_in` (bits 32*(y-CT_WR_CNT) upward). A debug write to such an entry changes nothing.
- R5: While `core_en` is high, a debug write changes no register and a debug read returns zero.
- R6: An address with either of bits 1:0 set, or at or above 0x100, is reserved. A write there changes nothing, and a read returns zero.
- R7: `r30_pulse` is high for exactly the one cycle after an accepted write to register 30, from the debug port or from the core port.
- R8: `rsp_valid` is high in the cycle after each request and low otherwise, and `rsp_rdata` is valid in that cycle. `req_ready` is always high.
- R9: A core write (`core_we` with `core_en` high) updates the register file. `core_rdata` shows register `core_ridx` combinationally, including values written through the debug port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Core running; high blocks debug access |
| req_valid | input | 1 | Debug request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | DATA_W | Debug write data |
| req_ready | output | 1 | Always high; requests never stall |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and for refused reads |
| core_we | input | 1 | Core register-file write enable |
| core_widx | input | 5 | Core write index |
| core_wdata | input | DATA_W | Core write data |
| core_ridx | input | 5 | Core read index |
| core_rdata | output | DATA_W | Core read data, combinational |
| ct_ro_in | input | RO_BUS_W | Values for the read-only constants entries |
| r30_pulse | output | 1 | One-cycle pulse after a write to register 30 |

## Verification
A request driven before clock edge N is captured at edge N. Its response (`rsp_valid` and `rsp_rdata`) and any register-30 pulse appear right after edge N, and the pulse is gone after edge N+1. A register updated at edge N shows on `core_rdata` right after that edge. The bench drives on the falling edge and samples on the next falling edge, half a cycle after the capturing edge. It checks the pulse again one falling edge later. For each dropped or ignored write, the bench reads the targeted register back through the port. It also reads the alias that a truncated decode would hit.

// File: rtl/dbg_regport_pkg.sv
package dbg_regport_pkg;
    localparam int IDX_W = 5;
    localparam int TBL_DEPTH = 1 << IDX_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_GPR  = 2'd1,
        TGT_CT   = 2'd2
    } dbg_tgt_e;

    typedef struct packed {
        dbg_tgt_e         tgt;
        logic [IDX_W-1:0] idx;
    } dbg_dec_t;
endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
    import dbg_regport_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dbg_dec_t          dec
);
    localparam int WIN_BITS = IDX_W + 3;  // two tables of words

    logic aligned;
    logic in_window;

    always_comb begin
        aligned   = (addr[1:0] == 2'b00);
        in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
        dec.idx   = addr[WIN_BITS-2:2];
        if (!aligned || !in_window) begin
            dec.tgt = TGT_NONE;
        end else if (addr[WIN_BITS-1]) begin
            dec.tgt = TGT_CT;
        end else begin
            dec.tgt = TGT_GPR;
        end
    end
endmodule

// File: rtl/dbg_gpr_file.sv
module dbg_gpr_file #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 32,
    parameter int IDX_W     = 5,
    parameter int PULSE_IDX = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_we,
    input  logic [IDX_W-1:0]  core_widx,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              dbg_we,
    input  logic [IDX_W-1:0]  dbg_widx,
    input  logic [DATA_W-1:0] dbg_wdata,
    input  logic [IDX_W-1:0]  dbg_ridx,
    output logic [DATA_W-1:0] dbg_rdata,
    input  logic [IDX_W-1:0]  core_ridx,
    output logic [DATA_W-1:0] core_rdata,
    output logic              pulse
);
    localparam logic [IDX_W-1:0] PULSE_SEL = IDX_W'(PULSE_IDX);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
        logic                         pulse;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (core_we) begin
            st_d.regs[core_widx] = core_wdata;
            st_d.pulse = (core_widx == PULSE_SEL);
        end else if (dbg_we) begin
            st_d.regs[dbg_widx] = dbg_wdata;
            st_d.pulse = (dbg_widx == PULSE_SEL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_rdata  = st_q.regs[dbg_ridx];
    assign core_rdata = st_q.regs[core_ridx];
    assign pulse      = st_q.pulse;
endmodule

// File: rtl/dbg_ct_table.sv
module dbg_ct_table #(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 32,
    parameter int IDX_W    = 5,
    parameter int WR_CNT   = 8,
    parameter int RO_BUS_W = (DEPTH - WR_CNT) * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [RO_BUS_W-1:0] ro_in,
    output logic [DATA_W-1:0]   rdata
);
    localparam int STORE_N = (WR_CNT > 0) ? WR_CNT : 1;

    typedef struct packed {
        logic [STORE_N-1:0][DATA_W-1:0] ent;
    } ct_state_t;

    ct_state_t st_d, st_q;
    logic [DEPTH-1:0][DATA_W-1:0] view;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WR_CNT; i++) begin
            if (we && (int'(idx) == i)) begin
                st_d.ent[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_view
        if (gi < WR_CNT) begin : g_rw
            assign view[gi] = st_q.ent[gi];
        end else begin : g_ro
            assign view[gi] = ro_in[(gi - WR_CNT)*DATA_W +: DATA_W];
        end
    end

    assign rdata = view[idx];
endmodule

// File: rtl/dbg_regport.sv
module dbg_regport
    import dbg_regport_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int CT_WR_CNT = 8,
    parameter int PULSE_IDX = 30,
    parameter int RO_BUS_W  = (TBL_DEPTH - CT_WR_CNT) * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_en,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                core_we,
    input  logic [IDX_W-1:0]    core_widx,
    input  logic [DATA_W-1:0]   core_wdata,
    input  logic [IDX_W-1:0]    core_ridx,
    output logic [DATA_W-1:0]   core_rdata,
    input  logic [RO_BUS_W-1:0] ct_ro_in,
    output logic                r30_pulse
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;

    dbg_dec_t          dec;
    logic              granted;
    logic              gpr_we;
    logic              ct_we;
    logic              core_we_eff;
    logic [DATA_W-1:0] gpr_rdata;
    logic [DATA_W-1:0] ct_rdata;
    rsp_state_t        rsp_d, rsp_q;

    dbg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    always_comb begin
        granted     = req_valid && !core_en;
        gpr_we      = granted && req_write && (dec.tgt == TGT_GPR);
        ct_we       = granted && req_write && (dec.tgt == TGT_CT);
        core_we_eff = core_we && core_en;
    end

    dbg_gpr_file #(
        .DATA_W    (DATA_W),
        .DEPTH     (TBL_DEPTH),
        .IDX_W     (IDX_W),
        .PULSE_IDX (PULSE_IDX)
    ) u_gpr (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_we    (core_we_eff),
        .core_widx  (core_widx),
        .core_wdata (core_wdata),
        .dbg_we     (gpr_we),
        .dbg_widx   (dec.idx),
        .dbg_wdata  (req_wdata),
        .dbg_ridx   (dec.idx),
        .dbg_rdata  (gpr_rdata),
        .core_ridx  (core_ridx),
        .core_rdata (core_rdata),
        .pulse      (r30_pulse)
    );

    dbg_ct_table #(
        .DATA_W   (DATA_W),
        .DEPTH    (TBL_DEPTH),
        .IDX_W    (IDX_W),
        .WR_CNT   (CT_WR_CNT),
        .RO_BUS_W (RO_BUS_W)
    ) u_ct (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ct_we),
        .idx   (dec.idx),
        .wdata (req_wdata),
        .ro_in (ct_ro_in),
        .rdata (ct_rdata)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (granted && !req_write) begin
            unique case (dec.tgt)
                TGT_GPR: rsp_d.rdata = gpr_rdata;
                TGT_CT:  rsp_d.rdata = ct_rdata;
                default: rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/dbg_regport_chk.sv
module dbg_regport_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int CT_WR_CNT = 8,
    parameter int PULSE_IDX = 30,
    parameter int RO_BUS_W  = (32 - CT_WR_CNT) * DATA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                core_en,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                core_we,
    input logic [4:0]          core_widx,
    input logic [RO_BUS_W-1:0] ct_ro_in,
    input logic                r30_pulse
);
    logic              reserved;
    logic              is_ro_ct;
    int                ro_idx;
    logic [DATA_W-1:0] ro_sel;
    logic              r30_write;

    always_comb begin
        reserved  = (req_addr[1:0] != 2'b00) || (req_addr >= ADDR_W'(256));
        is_ro_ct  = !reserved && req_addr[7] && (int'(req_addr[6:2]) >= CT_WR_CNT);
        ro_idx    = is_ro_ct ? (int'(req_addr[6:2]) - CT_WR_CNT) : 0;
        ro_sel    = ct_ro_in[ro_idx*DATA_W +: DATA_W];
        r30_write = (core_en && core_we && (int'(core_widx) == PULSE_IDX)) ||
                    (!core_en && req_valid && req_write &&
                     (req_addr == ADDR_W'(PULSE_IDX*4)));
    end

    assert_rsp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_running_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && core_en) |=> (rsp_rdata == '0));
    assert_reserved_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && reserved) |=> (rsp_rdata == '0));
    assert_ro_entry_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !core_en && is_ro_ct) |=> (rsp_rdata == $past(ro_sel)));
    assert_pulse_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r30_pulse |-> $past(r30_write));
    assert_pulse_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r30_write |=> r30_pulse);
endmodule

bind dbg_regport dbg_regport_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CT_WR_CNT (CT_WR_CNT),
    .PULSE_IDX (PULSE_IDX),
    .RO_BUS_W  (RO_BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_en   (core_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .core_we   (core_we),
    .core_widx (core_widx),
    .ct_ro_in  (ct_ro_in),
    .r30_pulse (r30_pulse)
);

// File: tb/dbg_regport_tb_top.sv
module dbg_regport_tb_top;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int WRC = 8;
    localparam int ROW = (32 - WRC) * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          core_we = 1'b0;
    logic [4:0]    core_widx = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [4:0]    core_ridx = '0;
    logic [DW-1:0] core_rdata;
    logic [ROW-1:0] ct_ro_in;
    logic          r30_pulse;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    for (genvar gi = WRC; gi < 32; gi++) begin : g_ro
        assign ct_ro_in[(gi-WRC)*DW +: DW] = 32'hC0DE_0000 + gi;
    end

    dbg_regport #(.DATA_W(DW), .ADDR_W(AW), .CT_WR_CNT(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .core_en(core_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_we(core_we), .core_widx(core_widx), .core_wdata(core_wdata),
        .core_ridx(core_ridx), .core_rdata(core_rdata),
        .ct_ro_in(ct_ro_in), .r30_pulse(r30_pulse)
    );

    typedef struct packed {
        logic          wr;
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;   // write data, or expected read data
        logic [3:0]    req;    // requirement number for messages
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'h014, 32'hA5A5_0001, 4'd2},  // R2 write reg5
        '{1'b0, 1'b0, 12'h014, 32'hA5A5_0001, 4'd2},  // R2
        '{1'b1, 1'b0, 12'h07C, 32'hFFFF_FFFF, 4'd2},  // R2 reg31
        '{1'b0, 1'b0, 12'h07C, 32'hFFFF_FFFF, 4'd2},  // R2
        '{1'b0, 1'b0, 12'h000, 32'h0000_0000, 4'd1},  // R1 reg0 untouched
        '{1'b1, 1'b0, 12'h088, 32'h1234_5678, 4'd3},  // R3 ct2
        '{1'b0, 1'b0, 12'h088, 32'h1234_5678, 4'd3},  // R3
        '{1'b1, 1'b0, 12'h09C, 32'h0BAD_F00D, 4'd3},  // R3 ct7 top writable
        '{1'b0, 1'b0, 12'h09C, 32'h0BAD_F00D, 4'd3},  // R3
        '{1'b1, 1'b0, 12'h0A0, 32'hDEAD_BEEF, 4'd4},  // R4 ct8 read-only
        '{1'b0, 1'b0, 12'h0A0, 32'hC0DE_0008, 4'd4},  // R4
        '{1'b0, 1'b0, 12'h0FC, 32'hC0DE_001F, 4'd4},  // R4 ct31
        '{1'b1, 1'b1, 12'h014, 32'h1111_1111, 4'd5},  // R5 write while running
        '{1'b0, 1'b1, 12'h014, 32'h0000_0000, 4'd5},  // R5 read while running
        '{1'b0, 1'b0, 12'h014, 32'hA5A5_0001, 4'd5},  // R5 reg5 kept
        '{1'b1, 1'b1, 12'h088, 32'h2222_2222, 4'd5},  // R5 ct write while running
        '{1'b0, 1'b0, 12'h088, 32'h1234_5678, 4'd5},  // R5 ct2 kept
        '{1'b1, 1'b0, 12'h016, 32'h3333_3333, 4'd6},  // R6 misaligned
        '{1'b0, 1'b0, 12'h014, 32'hA5A5_0001, 4'd6},  // R6
        '{1'b0, 1'b0, 12'h016, 32'h0000_0000, 4'd6},  // R6 misaligned read
        '{1'b1, 1'b0, 12'h114, 32'h4444_4444, 4'd6},  // R6 above window
        '{1'b0, 1'b0, 12'h014, 32'hA5A5_0001, 4'd6},  // R6 alias intact
        '{1'b0, 1'b0, 12'h188, 32'h0000_0000, 4'd6},  // R6 above window read
        '{1'b0, 1'b0, 12'h188, 32'h0000_0000, 4'd6}   // R6
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge (one capturing edge between)
    task automatic bus(input logic wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", DW'(rsp_valid), 0);
        check("R1 pulse", DW'(r30_pulse), 0);
        check("R8 req_ready", DW'(req_ready), 1);
        core_ridx = 5'd30;
        #1 check("R1 reg30 via core", core_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            core_en = VECS[i].en;
            bus(VECS[i].wr, VECS[i].addr, VECS[i].data);
            check($sformatf("R8 valid vec%0d", i), DW'(rsp_valid), 1);
            if (VECS[i].wr)
                check($sformatf("R%0d wr-rsp vec%0d", VECS[i].req, i), rsp_rdata, 0);
            else
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rsp_rdata, VECS[i].data);
            core_en = 1'b0;
        end
        @(negedge clk);
        check("R8 idle no rsp", DW'(rsp_valid), 0);

        // R7 pulse from debug write to reg30
        bus(1'b1, 12'h078, 32'h0000_00F0);
        check("R7 pulse after dbg write", DW'(r30_pulse), 1);
        @(negedge clk);
        check("R7 pulse one cycle", DW'(r30_pulse), 0);
        bus(1'b1, 12'h074, 32'h1);
        check("R7 no pulse reg29", DW'(r30_pulse), 0);
        core_en = 1'b1;
        bus(1'b1, 12'h078, 32'h5);
        check("R7 no pulse when running", DW'(r30_pulse), 0);

        // R9 core port
        core_ridx = 5'd30;
        #1 check("R9 core sees dbg write", core_rdata, 32'h0000_00F0);
        @(negedge clk);
        core_we = 1'b1; core_widx = 5'd3; core_wdata = 32'hCAFE_0003;
        @(negedge clk);
        core_we = 1'b0; core_ridx = 5'd3;
        #1 check("R9 core write", core_rdata, 32'hCAFE_0003);
        check("R7 no pulse core reg3", DW'(r30_pulse), 0);
        core_we = 1'b1; core_widx = 5'd30; core_wdata = 32'h77;
        @(negedge clk);
        core_we = 1'b0;
        check("R7 pulse after core write", DW'(r30_pulse), 1);
        @(negedge clk);
        check("R7 core pulse one cycle", DW'(r30_pulse), 0);
        core_en = 1'b0;
        bus(1'b0, 12'h00C, '0);
        check("R9 dbg reads core value", rsp_rdata, 32'hCAFE_0003);

        // R1 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus(1'b0, 12'h014, '0);
        check("R1 reg5 cleared", rsp_rdata, 0);
        bus(1'b0, 12'h088, '0);
        check("R1 ct2 cleared", rsp_rdata, 0);
        bus(1'b0, 12'h0A4, '0);
        check("R4 ct9 after reset", rsp_rdata, 32'hC0DE_0009);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule